// File: doc/BRIEF.md
# Host-Side Frame Receive Parser and Shadow Register Mapper

This block sits on the host side of a serial storage link's transport layer, just above the link layer. It takes 32-bit words that arrive with a start marker and an end marker. It collects the header words of each frame and reads the type code in the low byte of the first word. It then checks that the number of words matches the exact length that the type requires. Only when the end marker arrives does it copy the relevant fields into a host shadow register set: status, error, 48-bit block address, sector count and device.

For each accepted frame type the block gives a one-cycle event pulse. It also gives an interrupt pulse when the frame's interrupt flag is set, and holds the direction and auto-activate flags from the setup frames. A frame with an unknown type, or with the wrong number of words for its type, leaves every register unchanged and raises an error pulse. The words of a data frame that follow its header are forwarded on a payload port, one cycle after each arrives. CRC checking and flow control belong to the link layer and are not part of this block.

Top module: `fis_rx_mapper`

## Requirements
- R1: After reset all shadow registers, held flags, event pulses, the interrupt pulse, the error pulse and the payload outputs are zero.
- R2: A frame of type 34h that is exactly 5 words long loads the following fields. Status comes from word0[23:16] and error from word0[31:24]. The block address is {word2[23:0], word1[23:0]}. Device comes from word1[31:24] and count from word3[15:0]. The frame pulses evt_reg. Registers and pulse appear on the second rising edge after the end-marker word is sampled.
- R3: A frame of type A1h that is exactly 2 words long loads the following fields. Error comes from word0[31:24]. Status bits 6:4 come from word0[22:20] and status bits 2:0 from word0[18:16]. Status bits 7 and 3 keep their old values. The frame pulses evt_sdb.
- R4: For accepted frames of types 34h, A1h, 41h and 5Fh, irq_pulse goes high together with the event pulse exactly when word0[14] is 1. At most one event pulse is high in any cycle.
- R5: A frame of type 39h that is exactly 1 word long pulses evt_dma_act and changes no shadow register.
- R6: A frame of type 41h that is exactly 7 words long pulses evt_dma_setup. It loads dma_dir from word0[13] and dma_auto from word0[15].
- R7: A frame of type 5Fh that is exactly 5 words long pulses evt_pio_setup and loads pio_dir from word0[13].
- R8: A frame of type 58h that is exactly 3 words long only pulses evt_bist. No register changes.
- R9: A frame whose type is none of 34h, 39h, 41h, 46h, 58h, 5Fh or A1h raises err_pulse. It raises no event pulse and changes no register.
- R10: A known non-data frame whose word count differs from its required length raises err_pulse. It raises no event pulse and changes no register.
- R11: For a type 46h frame of any length, every word after the first appears on pl_data with pl_valid high, one cycle after it is sampled. pl_last is high for the end-marker word. The frame raises neither an event nor an error pulse.
- R12: Shadow registers do not change while a frame is in progress, nor on the edge that samples its end marker.
- R13: A valid word without a start marker outside a frame is ignored, including one that carries an end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | A word is present this cycle |
| rx_sof | input | 1 | The word is the first of a frame |
| rx_eof | input | 1 | The word is the last of a frame |
| rx_dw | input | 32 | Received word |
| sh_status | output | 8 | Shadow status register |
| sh_error | output | 8 | Shadow error register |
| sh_lba | output | 48 | Shadow block address |
| sh_count | output | 16 | Shadow sector count |
| sh_device | output | 8 | Shadow device register |
| dma_dir | output | 1 | Direction flag from the last DMA setup frame |
| dma_auto | output | 1 | Auto-activate flag from the last DMA setup frame |
| pio_dir | output | 1 | Direction flag from the last PIO setup frame |
| evt_reg | output | 1 | Register frame accepted |
| evt_sdb | output | 1 | Set-bits frame accepted |
| evt_dma_act | output | 1 | DMA activate frame accepted |
| evt_dma_setup | output | 1 | DMA setup frame accepted |
| evt_pio_setup | output | 1 | PIO setup frame accepted |
| evt_bist | output | 1 | Loopback test request received |
| irq_pulse | output | 1 | Interrupt flag seen in an accepted frame |
| err_pulse | output | 1 | Frame dropped: unknown type or wrong length |
| pl_valid | output | 1 | Payload word valid |
| pl_data | output | 32 | Payload word |
| pl_last | output | 1 | Payload word is the last of its frame |

## Verification
The bench sends a set-bits frame whose ignored status positions are set to 1. A mapper that writes the whole status byte would then corrupt bits 7 and 3. It sends set-bits and register frames that are one word too long or too short. A design that checks only the type would accept them and overwrite the registers. It watches the status register after every word of a frame and on the end-marker edge itself, to catch a mapper that commits early. It also sends stray words, with an end marker, outside any frame, and a data frame whose header must not reach the payload port. These catch a collector that starts frames without a start marker or forwards the type word.

// File: rtl/fis_rx_pkg.sv
package fis_rx_pkg;

  localparam logic [7:0] FT_REG_D2H   = 8'h34;
  localparam logic [7:0] FT_DMA_ACT   = 8'h39;
  localparam logic [7:0] FT_DMA_SETUP = 8'h41;
  localparam logic [7:0] FT_DATA      = 8'h46;
  localparam logic [7:0] FT_BIST      = 8'h58;
  localparam logic [7:0] FT_PIO_SETUP = 8'h5F;
  localparam logic [7:0] FT_SDB       = 8'hA1;

  localparam int IRQ_BIT  = 14;
  localparam int DIR_BIT  = 13;
  localparam int AUTO_BIT = 15;

  typedef struct packed {
    logic reg_d2h;
    logic sdb;
    logic dma_act;
    logic dma_setup;
    logic pio_setup;
    logic bist;
    logic irq;
    logic bad;
  } fis_cmd_t;

  function automatic logic [3:0] fis_exp_len(input logic [7:0] t);
    case (t)
      FT_REG_D2H:   return 4'd5;
      FT_DMA_ACT:   return 4'd1;
      FT_DMA_SETUP: return 4'd7;
      FT_BIST:      return 4'd3;
      FT_PIO_SETUP: return 4'd5;
      FT_SDB:       return 4'd2;
      default:      return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/fis_frame_collect.sv
module fis_frame_collect #(
  parameter int DW_W     = 32,
  parameter int HDR_KEEP = 4,
  parameter int CNT_W    = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rx_valid,
  input  logic                           rx_sof,
  input  logic                           rx_eof,
  input  logic [DW_W-1:0]                rx_dw,
  output logic                           done,
  output logic [CNT_W-1:0]               len,
  output logic [HDR_KEEP-1:0][DW_W-1:0]  hdr,
  output logic                           pl_valid,
  output logic [DW_W-1:0]                pl_data,
  output logic                           pl_last
);
  import fis_rx_pkg::*;

  logic                          in_frame_q, in_frame_n;
  logic                          data_q, data_n;
  logic                          done_q, done_n;
  logic [CNT_W-1:0]              cnt_q, cnt_n;
  logic [HDR_KEEP-1:0][DW_W-1:0] hdr_q, hdr_n;
  logic                          plv_q, plv_n;
  logic [DW_W-1:0]               pld_q, pld_n;
  logic                          pll_q, pll_n;
  logic                          start, cont, take;
  logic [CNT_W-1:0]              idx;

  assign start = rx_valid & rx_sof;
  assign cont  = rx_valid & ~rx_sof & in_frame_q;
  assign take  = start | cont;
  assign idx   = start ? '0 : cnt_q;

  always_comb begin
    cnt_n = cnt_q;
    if (start)
      cnt_n = CNT_W'(1);
    else if (cont && cnt_q != '1)
      cnt_n = cnt_q + CNT_W'(1);
  end

  always_comb begin
    in_frame_n = take ? ~rx_eof : in_frame_q;
    done_n     = take & rx_eof;
    data_n     = start ? (rx_dw[7:0] == FT_DATA) : data_q;
    plv_n      = cont & data_q;
    pld_n      = cont ? rx_dw : pld_q;
    pll_n      = cont & data_q & rx_eof;
  end

  for (genvar g = 0; g < HDR_KEEP; g++) begin : g_hdr
    always_comb hdr_n[g] = (take && idx == CNT_W'(g)) ? rx_dw : hdr_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      data_q     <= 1'b0;
      done_q     <= 1'b0;
      cnt_q      <= '0;
      hdr_q      <= '0;
      plv_q      <= 1'b0;
      pld_q      <= '0;
      pll_q      <= 1'b0;
    end else begin
      in_frame_q <= in_frame_n;
      data_q     <= data_n;
      done_q     <= done_n;
      cnt_q      <= cnt_n;
      hdr_q      <= hdr_n;
      plv_q      <= plv_n;
      pld_q      <= pld_n;
      pll_q      <= pll_n;
    end
  end

  assign done     = done_q;
  assign len      = cnt_q;
  assign hdr      = hdr_q;
  assign pl_valid = plv_q;
  assign pl_data  = pld_q;
  assign pl_last  = pll_q;

endmodule

// File: rtl/fis_type_decode.sv
module fis_type_decode #(
  parameter int DW_W  = 32,
  parameter int CNT_W = 12
) (
  input  logic                 done,
  input  logic [CNT_W-1:0]     len,
  input  logic [DW_W-1:0]      w0,
  output fis_rx_pkg::fis_cmd_t cmd
);
  import fis_rx_pkg::*;

  logic [7:0] ftype;
  logic       known;
  logic       len_ok;
  logic       unused_w0;

  assign ftype     = w0[7:0];
  assign unused_w0 = ^{w0[DW_W-1:15], w0[13:8]};

  always_comb begin
    known  = (fis_exp_len(ftype) != 4'd0);
    len_ok = (len == CNT_W'(fis_exp_len(ftype)));
  end

  always_comb begin
    cmd = '0;
    if (done && ftype != FT_DATA) begin
      if (!known || !len_ok) begin
        cmd.bad = 1'b1;
      end else begin
        cmd.reg_d2h   = (ftype == FT_REG_D2H);
        cmd.sdb       = (ftype == FT_SDB);
        cmd.dma_act   = (ftype == FT_DMA_ACT);
        cmd.dma_setup = (ftype == FT_DMA_SETUP);
        cmd.pio_setup = (ftype == FT_PIO_SETUP);
        cmd.bist      = (ftype == FT_BIST);
        cmd.irq       = w0[IRQ_BIT] & (cmd.reg_d2h | cmd.sdb |
                                       cmd.dma_setup | cmd.pio_setup);
      end
    end
  end

endmodule

// File: rtl/fis_shadow_regs.sv
module fis_shadow_regs #(
  parameter int DW_W  = 32,
  parameter int LBA_W = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  fis_rx_pkg::fis_cmd_t cmd,
  input  logic [DW_W-1:0]      w0,
  input  logic [DW_W-1:0]      w1,
  input  logic [DW_W-1:0]      w2,
  input  logic [DW_W-1:0]      w3,
  output logic [7:0]           sh_status,
  output logic [7:0]           sh_error,
  output logic [LBA_W-1:0]     sh_lba,
  output logic [15:0]          sh_count,
  output logic [7:0]           sh_device,
  output logic                 dma_dir,
  output logic                 dma_auto,
  output logic                 pio_dir,
  output logic [5:0]           evt,
  output logic                 irq_pulse,
  output logic                 err_pulse
);
  import fis_rx_pkg::*;

  localparam int HALF = LBA_W / 2;

  logic [7:0]       st_q, st_n, er_q, er_n, dev_q, dev_n;
  logic [LBA_W-1:0] lba_q, lba_n;
  logic [15:0]      cnt_q, cnt_n;
  logic             ddir_q, ddir_n, dauto_q, dauto_n, pdir_q, pdir_n;
  logic [5:0]       evt_q, evt_n;
  logic             irq_q, err_q;
  logic             unused_fields;

  assign unused_fields = ^{w0[12:0], w0[IRQ_BIT], w2[DW_W-1:HALF],
                           w3[DW_W-1:16], cmd.irq, cmd.bad};

  always_comb begin
    st_n    = st_q;
    er_n    = er_q;
    lba_n   = lba_q;
    cnt_n   = cnt_q;
    dev_n   = dev_q;
    ddir_n  = ddir_q;
    dauto_n = dauto_q;
    pdir_n  = pdir_q;
    if (cmd.reg_d2h) begin
      st_n  = w0[23:16];
      er_n  = w0[31:24];
      lba_n = {w2[HALF-1:0], w1[HALF-1:0]};
      dev_n = w1[31:24];
      cnt_n = w3[15:0];
    end
    if (cmd.sdb) begin
      st_n = {st_q[7], w0[22:20], st_q[3], w0[18:16]};
      er_n = w0[31:24];
    end
    if (cmd.dma_setup) begin
      ddir_n  = w0[DIR_BIT];
      dauto_n = w0[AUTO_BIT];
    end
    if (cmd.pio_setup)
      pdir_n = w0[DIR_BIT];
    evt_n = {cmd.bist, cmd.pio_setup, cmd.dma_setup, cmd.dma_act,
             cmd.sdb, cmd.reg_d2h};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      er_q    <= '0;
      lba_q   <= '0;
      cnt_q   <= '0;
      dev_q   <= '0;
      ddir_q  <= 1'b0;
      dauto_q <= 1'b0;
      pdir_q  <= 1'b0;
      evt_q   <= '0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      er_q    <= er_n;
      lba_q   <= lba_n;
      cnt_q   <= cnt_n;
      dev_q   <= dev_n;
      ddir_q  <= ddir_n;
      dauto_q <= dauto_n;
      pdir_q  <= pdir_n;
      evt_q   <= evt_n;
      irq_q   <= cmd.irq;
      err_q   <= cmd.bad;
    end
  end

  assign sh_status = st_q;
  assign sh_error  = er_q;
  assign sh_lba    = lba_q;
  assign sh_count  = cnt_q;
  assign sh_device = dev_q;
  assign dma_dir   = ddir_q;
  assign dma_auto  = dauto_q;
  assign pio_dir   = pdir_q;
  assign evt       = evt_q;
  assign irq_pulse = irq_q;
  assign err_pulse = err_q;

endmodule

// File: rtl/fis_rx_mapper.sv
module fis_rx_mapper #(
  parameter int DW_W     = 32,
  parameter int HDR_KEEP = 4,
  parameter int CNT_W    = 12,
  parameter int LBA_W    = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic [DW_W-1:0]  rx_dw,
  output logic [7:0]       sh_status,
  output logic [7:0]       sh_error,
  output logic [LBA_W-1:0] sh_lba,
  output logic [15:0]      sh_count,
  output logic [7:0]       sh_device,
  output logic             dma_dir,
  output logic             dma_auto,
  output logic             pio_dir,
  output logic             evt_reg,
  output logic             evt_sdb,
  output logic             evt_dma_act,
  output logic             evt_dma_setup,
  output logic             evt_pio_setup,
  output logic             evt_bist,
  output logic             irq_pulse,
  output logic             err_pulse,
  output logic             pl_valid,
  output logic [DW_W-1:0]  pl_data,
  output logic             pl_last
);
  import fis_rx_pkg::*;

  logic [1:0]                    rs_q;
  logic                          rst_i;
  logic                          done;
  logic [CNT_W-1:0]              len;
  logic [HDR_KEEP-1:0][DW_W-1:0] hdr;
  fis_cmd_t                      cmd;
  logic [5:0]                    evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  fis_frame_collect #(.DW_W(DW_W), .HDR_KEEP(HDR_KEEP), .CNT_W(CNT_W)) u_collect (
    .clk(clk), .rst_n(rst_i),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_dw(rx_dw),
    .done(done), .len(len), .hdr(hdr),
    .pl_valid(pl_valid), .pl_data(pl_data), .pl_last(pl_last)
  );

  fis_type_decode #(.DW_W(DW_W), .CNT_W(CNT_W)) u_decode (
    .done(done), .len(len), .w0(hdr[0]), .cmd(cmd)
  );

  fis_shadow_regs #(.DW_W(DW_W), .LBA_W(LBA_W)) u_shadow (
    .clk(clk), .rst_n(rst_i), .cmd(cmd),
    .w0(hdr[0]), .w1(hdr[1]), .w2(hdr[2]), .w3(hdr[3]),
    .sh_status(sh_status), .sh_error(sh_error), .sh_lba(sh_lba),
    .sh_count(sh_count), .sh_device(sh_device),
    .dma_dir(dma_dir), .dma_auto(dma_auto), .pio_dir(pio_dir),
    .evt(evt), .irq_pulse(irq_pulse), .err_pulse(err_pulse)
  );

  assign {evt_bist, evt_pio_setup, evt_dma_setup, evt_dma_act, evt_sdb, evt_reg} = evt;

endmodule

// File: rtl/fis_rx_mapper_chk.sv
module fis_rx_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  sh_status,
  input logic [47:0] sh_lba,
  input logic        dma_dir,
  input logic        evt_reg,
  input logic        evt_sdb,
  input logic        evt_dma_act,
  input logic        evt_dma_setup,
  input logic        evt_pio_setup,
  input logic        evt_bist,
  input logic        irq_pulse,
  input logic        err_pulse,
  input logic        pl_valid,
  input logic        pl_last
);

  p_evt_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_reg, evt_sdb, evt_dma_act, evt_dma_setup, evt_pio_setup, evt_bist}));

  p_irq_with_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (evt_reg || evt_sdb || evt_dma_setup || evt_pio_setup));

  p_err_no_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !(evt_reg || evt_sdb || evt_dma_act || evt_dma_setup ||
                    evt_pio_setup || evt_bist || irq_pulse));

  p_sdb_keep_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sdb |-> (sh_status[7] == $past(sh_status[7]) && sh_status[3] == $past(sh_status[3])));

  p_status_commit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sh_status) |-> (evt_reg || evt_sdb));

  p_lba_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sh_lba) |-> evt_reg);

  p_dir_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dma_dir) |-> evt_dma_setup);

  p_last_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pl_last |-> pl_valid);

endmodule

bind fis_rx_mapper fis_rx_mapper_chk u_chk (.*);

// File: tb/fis_rx_mapper_bench.sv
module fis_rx_mapper_bench;

  typedef struct packed {
    logic [31:0] w0, w1, w2, w3;
    logic [3:0]  len;
    logic [7:0]  st, er;
    logic [5:0]  ev;
    logic        irq, bad;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{32'h51584034, 32'hE0123456, 32'h00ABCDEF, 32'h00000010, 4'd5, 8'h58, 8'h51, 6'b000001, 1'b1, 1'b0},
    '{32'h04DB00A1, 32'h0, 32'h0, 32'h0, 4'd2, 8'h5B, 8'h04, 6'b000010, 1'b0, 1'b0},
    '{32'hFF0040A1, 32'h0, 32'h0, 32'h0, 4'd3, 8'h5B, 8'h04, 6'b000000, 1'b0, 1'b1},
    '{32'h77664027, 32'h0, 32'h0, 32'h0, 4'd5, 8'h5B, 8'h04, 6'b000000, 1'b0, 1'b1},
    '{32'h00000039, 32'h0, 32'h0, 32'h0, 4'd1, 8'h5B, 8'h04, 6'b000100, 1'b0, 1'b0},
    '{32'h0000E041, 32'h0, 32'h0, 32'h0, 4'd7, 8'h5B, 8'h04, 6'b001000, 1'b1, 1'b0},
    '{32'h0000205F, 32'h0, 32'h0, 32'h0, 4'd5, 8'h5B, 8'h04, 6'b010000, 1'b0, 1'b0},
    '{32'h00000058, 32'h0, 32'h0, 32'h0, 4'd3, 8'h5B, 8'h04, 6'b100000, 1'b0, 1'b0},
    '{32'h99884034, 32'h0, 32'h0, 32'h0, 4'd4, 8'h5B, 8'h04, 6'b000000, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [31:0] rx_dw = '0;
  logic [7:0]  sh_status, sh_error, sh_device;
  logic [47:0] sh_lba;
  logic [15:0] sh_count;
  logic        dma_dir, dma_auto, pio_dir;
  logic        evt_reg, evt_sdb, evt_dma_act, evt_dma_setup, evt_pio_setup, evt_bist;
  logic        irq_pulse, err_pulse, pl_valid, pl_last;
  logic [31:0] pl_data;
  logic [5:0]  ev;
  int          checks = 0;
  int          errors = 0;

  assign ev = {evt_bist, evt_pio_setup, evt_dma_setup, evt_dma_act, evt_sdb, evt_reg};

  always #5 clk = ~clk;

  fis_rx_mapper u_fis_rx_mapper (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_dw(rx_dw), .sh_status(sh_status), .sh_error(sh_error), .sh_lba(sh_lba),
    .sh_count(sh_count), .sh_device(sh_device), .dma_dir(dma_dir), .dma_auto(dma_auto),
    .pio_dir(pio_dir), .evt_reg(evt_reg), .evt_sdb(evt_sdb), .evt_dma_act(evt_dma_act),
    .evt_dma_setup(evt_dma_setup), .evt_pio_setup(evt_pio_setup), .evt_bist(evt_bist),
    .irq_pulse(irq_pulse), .err_pulse(err_pulse), .pl_valid(pl_valid),
    .pl_data(pl_data), .pl_last(pl_last)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic beat(input logic sof, input logic eof, input logic [31:0] dw);
    @(negedge clk);
    rx_valid = 1'b1; rx_sof = sof; rx_eof = eof; rx_dw = dw;
  endtask

  task automatic idle();
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_dw = '0;
  endtask

  task automatic send(input logic [31:0] w0, w1, w2, w3, input int n);
    for (int k = 0; k < n; k++)
      beat(k == 0, k == n - 1, k == 0 ? w0 : k == 1 ? w1 : k == 2 ? w2 : k == 3 ? w3 : 32'h0);
    idle();
    @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", sh_status, 0);
    chk("R1 lba", sh_lba, 0);
    chk("R1 flags", {dma_dir, dma_auto, pio_dir, ev, irq_pulse, err_pulse, pl_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].w0, VEC[i].w1, VEC[i].w2, VEC[i].w3, int'(VEC[i].len));
      chk($sformatf("R2 R3 status vec%0d", i), sh_status, VEC[i].st);
      chk($sformatf("R2 R3 error vec%0d", i), sh_error, VEC[i].er);
      chk($sformatf("R5 R7 R8 R9 R10 event vec%0d", i), ev, VEC[i].ev);
      chk($sformatf("R4 irq vec%0d", i), irq_pulse, VEC[i].irq);
      chk($sformatf("R9 R10 err vec%0d", i), err_pulse, VEC[i].bad);
      if (i == 0) begin
        chk("R2 lba", sh_lba, 48'hABCDEF123456);
        chk("R2 count", sh_count, 16'h0010);
        chk("R2 device", sh_device, 8'hE0);
      end
      if (i == 5) chk("R6 dir auto", {dma_dir, dma_auto}, 2'b11);
      if (i == 6) chk("R7 pio dir", pio_dir, 1'b1);
      @(negedge clk);
      chk($sformatf("R4 pulse width vec%0d", i), {ev, irq_pulse, err_pulse}, 0);
    end
    chk("R10 lba kept", sh_lba, 48'hABCDEF123456);

    // R6 second setup: direction cleared, auto kept
    send(32'h00008041, 0, 0, 0, 7);
    chk("R6 dir auto", {dma_dir, dma_auto}, 2'b01);

    // R12 nothing commits mid-frame or on the end-marker edge
    beat(1'b1, 1'b0, 32'h22114034);
    for (int k = 1; k < 5; k++) begin
      beat(1'b0, k == 4, 32'h0);
      chk("R12 mid-frame status", sh_status, 8'h5B);
    end
    idle();
    chk("R12 end-edge status", sh_status, 8'h5B);
    @(negedge clk);
    chk("R12 commit status", sh_status, 8'h11);
    chk("R12 commit error", sh_error, 8'h22);

    // R13 stray words outside a frame
    beat(1'b0, 1'b0, 32'h33334034);
    beat(1'b0, 1'b1, 32'h0);
    idle();
    @(negedge clk);
    chk("R13 no event", {ev, err_pulse}, 0);
    chk("R13 status kept", sh_status, 8'h11);

    // R11 data frame payload
    beat(1'b1, 1'b0, 32'h00000046);
    beat(1'b0, 1'b0, 32'hAAAA0001);
    chk("R11 header not forwarded", pl_valid, 1'b0);
    beat(1'b0, 1'b0, 32'hAAAA0002);
    chk("R11 word1", {pl_valid, pl_last, pl_data}, {2'b10, 32'hAAAA0001});
    beat(1'b0, 1'b1, 32'hAAAA0003);
    chk("R11 word2", {pl_valid, pl_last, pl_data}, {2'b10, 32'hAAAA0002});
    idle();
    chk("R11 last word", {pl_valid, pl_last, pl_data}, {2'b11, 32'hAAAA0003});
    @(negedge clk);
    chk("R11 no event no err", {pl_valid, ev, err_pulse}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule